// File: doc/BRIEF.md
# Addressable Octal Output Latch

This block holds one on/off bit for each of eight output channels. A three-bit binary address picks a channel, and a single data input sets it. While the active-low select input is low, the addressed channel's bit follows the data input on every clock. This lets software pulse-width modulate one channel, or sweep the address to write many channels without toggling select. When select returns high, every bit holds its value. An active-low clear empties all bits and takes priority over writing.

The output stage gates each bit with an active-high output enable and with an over-temperature shutdown flag, then produces two views. One is an on-control per channel. The other is a modelled open-drain pin level, which is low when the channel sinks and high when it is off. The shutdown flag has hysteresis: a hot input sets it, and only a separate cool-down input clears it. All control inputs are asynchronous to the block clock and pass through two-flop synchronizers before use.

Top module: `octal_addr_latch`

## Requirements
- R1: The address input is binary with bit 2 (C) as the most significant and bit 0 (A) as the least significant. Value k selects channel k, which is bit k of `out_on` and `pin_lvl`.
- R2: While synchronized `sel_n` is 0 and `clr_n` is 1, the addressed channel's bit takes the value of `din` on every clock, where 1 means on and 0 means off.
- R3: While synchronized `sel_n` is 1, no channel bit changes, whatever `addr` and `din` do.
- R4: If `addr` changes while `sel_n` stays 0, each newly addressed channel takes `din` in turn, and channels no longer addressed keep their last value.
- R5: Synchronized `clr_n` at 0 turns every channel bit off on the next clock, regardless of `sel_n`, `addr`, `din` and `oe`.
- R6: With `oe` at 0, every `out_on` bit is 0 and every `pin_lvl` bit is 1, and the channel bits are kept. With `oe` at 1, each output follows its bit.
- R7: `pin_lvl[k]` is the inverse of `out_on[k]`: an off channel reads 1 and an on channel reads 0.
- R8: `ot_hot` at 1 sets the shutdown flag, which forces all outputs off while the channel bits are kept.
- R9: The shutdown flag is cleared only by `ot_cool` at 1 with `ot_hot` at 0. If both are 1, the hot input wins.
- R10: After reset, every channel bit is off, shutdown is clear and output enable reads as 0, so `out_on` is 0 and `pin_lvl` is all ones.
- R11: A change on `sel_n`, `addr`, `din`, `clr_n`, `ot_hot` or `ot_cool` reaches the outputs on the third rising edge after it is applied. A change on `oe` reaches them on the second edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low select; low makes the addressed bit transparent |
| addr | input | 3 | Channel address, bit 2 = C (MSB), bit 0 = A (LSB) |
| din | input | 1 | Data written to the addressed channel |
| clr_n | input | 1 | Active-low clear of all channel bits |
| oe | input | 1 | Active-high output enable |
| ot_hot | input | 1 | Over-temperature trip; sets shutdown |
| ot_cool | input | 1 | Cool-down indication; releases shutdown |
| out_on | output | 8 | Per-channel on-control |
| pin_lvl | output | 8 | Modelled open-drain pin level (1 = off) |

## Verification
The assertions take for granted that the synchronized controls are coherent: address bits that change together reach the latch bank on the same edge. They also assume that `ot_hot` and `ot_cool` are levels and not pulses shorter than a clock. The stimulus changes inputs only at falling edges and holds each value for at least one full cycle. Most address sweeps use a Gray sequence so that no unintended address is visited. In the random phase, the reference model moves through the same two-stage delay, so simultaneous multi-bit address changes stay consistent with it.

// File: rtl/octlat_pkg.sv
package octlat_pkg;

    // Control inputs that share one synchronizer chain.
    typedef struct packed {
        logic sel_n;
        logic clr_n;
        logic oe;
        logic hot;
        logic cool;
        logic din;
    } ctl_t;

    localparam int unsigned CTL_W = $bits(ctl_t);

    // Reset image: deselected, not clearing, outputs disabled.
    localparam ctl_t CTL_IDLE = '{sel_n: 1'b1, clr_n: 1'b1, oe: 1'b0,
                                  hot: 1'b0, cool: 1'b0, din: 1'b0};

endpackage

// File: rtl/octlat_sync.sv
module octlat_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] st;
    } sync_s_t;

    sync_s_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.st[0] = d;
        for (int i = 1; i < int'(STAGES); i++) begin
            s_d.st[i] = s_q.st[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: {STAGES{RST_VAL}}};
        end else begin
            s_q <= s_d;
        end
    end

    assign q = s_q.st[STAGES-1];

endmodule

// File: rtl/octlat_bank.sv
module octlat_bank #(
    parameter int unsigned N_CH = 8,
    localparam int unsigned AW  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_n,
    input  logic            clr_n,
    input  logic            din,
    input  logic [AW-1:0]   addr,
    output logic [N_CH-1:0] lat
);

    typedef struct packed {
        logic [N_CH-1:0] bits;
    } bank_s_t;

    bank_s_t b_d, b_q;
    logic [N_CH-1:0] hit;

    // One comparator per channel for the address decode.
    for (genvar g = 0; g < int'(N_CH); g++) begin : g_dec
        assign hit[g] = (addr == AW'(g));
    end

    always_comb begin
        b_d = b_q;
        for (int i = 0; i < int'(N_CH); i++) begin
            if (!clr_n) begin
                b_d.bits[i] = 1'b0;
            end else if (!sel_n && hit[i]) begin
                b_d.bits[i] = din;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign lat = b_q.bits;

    // R5
    clr_wipes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (lat == '0));

    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n && clr_n) |=> $stable(lat));

    // R2
    follow_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && clr_n && (int'(addr) < int'(N_CH))) |=> (lat[$past(addr)] == $past(din)));

    // R4
    others_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && clr_n) |=> (((lat ^ $past(lat)) & ~$past(hit)) == '0));

endmodule

// File: rtl/octlat_thermal.sv
module octlat_thermal (
    input  logic clk,
    input  logic rst_n,
    input  logic hot,
    input  logic cool,
    output logic shut
);

    typedef struct packed {
        logic flag;
    } therm_s_t;

    therm_s_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (hot) begin
            t_d.flag = 1'b1;
        end else if (cool) begin
            t_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign shut = t_q.flag;

    // R8
    hot_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hot |=> shut);

    // R9
    cool_only_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shut && !cool) |=> shut);

endmodule

// File: rtl/octlat_drive.sv
module octlat_drive #(
    parameter int unsigned N_CH = 8
) (
    input  logic [N_CH-1:0] lat,
    input  logic            oe,
    input  logic            shut,
    output logic [N_CH-1:0] on,
    output logic [N_CH-1:0] pin
);

    logic gate;

    always_comb begin
        gate = oe && !shut;
        for (int i = 0; i < int'(N_CH); i++) begin
            on[i]  = lat[i] && gate;
            pin[i] = !on[i];
        end
    end

endmodule

// File: rtl/octal_addr_latch.sv
module octal_addr_latch #(
    parameter int unsigned N_CH   = 8,
    parameter int unsigned STAGES = 2,
    localparam int unsigned AW    = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_n,
    input  logic [AW-1:0]   addr,
    input  logic            din,
    input  logic            clr_n,
    input  logic            oe,
    input  logic            ot_hot,
    input  logic            ot_cool,
    output logic [N_CH-1:0] out_on,
    output logic [N_CH-1:0] pin_lvl
);
    import octlat_pkg::*;

    localparam int unsigned SW = CTL_W + AW;
    localparam logic [SW-1:0] SYNC_RST = {CTL_IDLE, {AW{1'b0}}};

    ctl_t            ctl_raw, ctl_s;
    logic [AW-1:0]   addr_s;
    logic [SW-1:0]   sync_in, sync_out;
    logic [N_CH-1:0] lat;
    logic            shut;

    always_comb begin
        ctl_raw.sel_n = sel_n;
        ctl_raw.clr_n = clr_n;
        ctl_raw.oe    = oe;
        ctl_raw.hot   = ot_hot;
        ctl_raw.cool  = ot_cool;
        ctl_raw.din   = din;
        sync_in       = {ctl_raw, addr};
    end

    octlat_sync #(.WIDTH(SW), .STAGES(STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sync_in),
        .q     (sync_out)
    );

    assign ctl_s  = ctl_t'(sync_out[SW-1:AW]);
    assign addr_s = sync_out[AW-1:0];

    octlat_bank #(.N_CH(N_CH)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .sel_n (ctl_s.sel_n),
        .clr_n (ctl_s.clr_n),
        .din   (ctl_s.din),
        .addr  (addr_s),
        .lat   (lat)
    );

    octlat_thermal u_therm (
        .clk   (clk),
        .rst_n (rst_n),
        .hot   (ctl_s.hot),
        .cool  (ctl_s.cool),
        .shut  (shut)
    );

    octlat_drive #(.N_CH(N_CH)) u_drive (
        .lat   (lat),
        .oe    (ctl_s.oe),
        .shut  (shut),
        .on    (out_on),
        .pin   (pin_lvl)
    );

    // R6
    blank_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_s.oe |-> (out_on == '0));

    // R8
    shutdown_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shut |-> (pin_lvl == '1));

    // R6
    enabled_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_s.oe && !shut) |-> (out_on == lat));

endmodule

// File: tb/sim_octal_addr_latch.sv
module sim_octal_addr_latch;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_n = 1'b1;
    logic [2:0] addr = 3'd0;
    logic       din = 1'b0;
    logic       clr_n = 1'b1;
    logic       oe = 1'b0;
    logic       ot_hot = 1'b0;
    logic       ot_cool = 1'b0;
    logic [7:0] out_on;
    logic [7:0] pin_lvl;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    string tag = "R10";

    always #2.5 clk = ~clk;

    octal_addr_latch u0 (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .addr(addr), .din(din),
        .clr_n(clr_n), .oe(oe), .ot_hot(ot_hot), .ot_cool(ot_cool),
        .out_on(out_on), .pin_lvl(pin_lvl)
    );

    // Behavioural reference: input samples queued through a two-deep delay.
    typedef struct {
        bit sel_n, clr_n, oe, hot, cool, din;
        int addr;
    } smp_t;

    smp_t pipe[$];
    bit [7:0] m_bits;
    bit       m_shut;

    function automatic smp_t idle_smp();
        smp_t s;
        s.sel_n = 1; s.clr_n = 1; s.oe = 0; s.hot = 0; s.cool = 0; s.din = 0; s.addr = 0;
        return s;
    endfunction

    initial begin
        pipe.push_back(idle_smp());
        pipe.push_back(idle_smp());
        m_bits = 0;
        m_shut = 0;
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe.delete();
            pipe.push_back(idle_smp());
            pipe.push_back(idle_smp());
            m_bits = 0;
            m_shut = 0;
        end else begin
            smp_t old, cur;
            old = pipe[0];
            if (!old.clr_n) m_bits = 0;
            else if (!old.sel_n) m_bits[old.addr] = old.din;
            if (old.hot) m_shut = 1;
            else if (old.cool) m_shut = 0;
            void'(pipe.pop_front());
            cur.sel_n = sel_n; cur.clr_n = clr_n; cur.oe = oe; cur.hot = ot_hot;
            cur.cool = ot_cool; cur.din = din; cur.addr = int'(addr);
            pipe.push_back(cur);
        end
    end

    function automatic bit [7:0] exp_on();
        if (pipe[0].oe && !m_shut) return m_bits;
        return 8'h00;
    endfunction

    // Every-cycle comparison against the model (R7 covered through pin_lvl).
    always @(negedge clk) begin
        if (!done) begin
            n_cmp++;
            if (out_on !== exp_on()) begin
                n_bad++;
                $display("FAIL %s out_on act=%h exp=%h t=%0t", tag, out_on, exp_on(), $time);
            end
            n_cmp++;
            if (pin_lvl !== ~exp_on()) begin
                n_bad++;
                $display("FAIL R7 pin_lvl act=%h exp=%h t=%0t", pin_lvl, ~exp_on(), $time);
            end
        end
    end

    task automatic chk(input string t, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", t, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input bit d, input int hold);
        @(negedge clk);
        sel_n = 0; addr = 3'(a); din = d;
        cyc(hold);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        // R10: reset state
        chk("R10 on", out_on, 8'h00);
        chk("R10 pin", pin_lvl, 8'hff);
        @(negedge clk); rst_n = 1;
        cyc(4);
        chk("R10 after release", out_on, 8'h00);

        // R1: decode pattern, C is address MSB
        tag = "R1";
        @(negedge clk); oe = 1;
        for (int i = 0; i < 8; i++) wr(i, (8'hA5 >> i) & 1, 3);
        @(negedge clk); sel_n = 1;
        cyc(4);
        chk("R1 pattern", out_on, 8'hA5);
        chk("R7 pattern pin", pin_lvl, 8'h5A);

        // R11: latency of data path
        tag = "R11";
        wr(1, 0, 4);
        chk("R11 setup", out_on, 8'hA5);
        @(negedge clk); din = 1;
        cyc(2);
        chk("R11 two edges", out_on, 8'hA5);
        cyc(1);
        chk("R11 three edges", out_on, 8'hA7);
        @(negedge clk); oe = 0;
        cyc(1);
        chk("R11 oe one edge", out_on, 8'hA7);
        cyc(1);
        chk("R11 oe two edges", out_on, 8'h00);
        @(negedge clk); oe = 1;

        // R2: pulse-width modulate channel 3
        tag = "R2";
        @(negedge clk); addr = 3'd3;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); din = k[0];
            cyc(5);
            chk("R2 pwm", out_on & 8'h08, (k[0]) ? 8'h08 : 8'h00);
        end
        @(negedge clk); din = 1;
        cyc(4);
        @(negedge clk); sel_n = 1;
        cyc(4);

        // R3: hold while deselected
        tag = "R3";
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); addr = 3'($urandom); din = $urandom;
        end
        cyc(4);
        chk("R3 hold", out_on, 8'hAF);

        // R5: clear beats select and data, with oe low
        tag = "R5";
        @(negedge clk); sel_n = 0; addr = 3'd6; din = 1; clr_n = 0; oe = 0;
        cyc(5);
        @(negedge clk); sel_n = 1; clr_n = 1; oe = 1;
        cyc(4);
        chk("R5 wiped", out_on, 8'h00);

        // R1: single upper channel
        tag = "R1";
        wr(4, 1, 3);
        @(negedge clk); sel_n = 1;
        cyc(4);
        chk("R1 addr4", out_on, 8'h10);

        // R4: Gray sweep on, then partial sweep off
        tag = "R4";
        begin
            int gray[8] = '{0, 1, 3, 2, 6, 7, 5, 4};
            for (int i = 0; i < 8; i++) wr(gray[i], 1, 3);
            @(negedge clk); sel_n = 1;
            cyc(4);
            chk("R4 sweep on", out_on, 8'hff);
            for (int i = 0; i < 4; i++) wr(gray[i], 0, 3);
            @(negedge clk); sel_n = 1;
            cyc(4);
            chk("R4 sweep off", out_on, 8'hf0);
        end

        // R6: blanking keeps contents
        tag = "R6";
        @(negedge clk); oe = 0;
        cyc(4);
        chk("R6 blanked", out_on, 8'h00);
        chk("R6 blanked pin", pin_lvl, 8'hff);
        @(negedge clk); oe = 1;
        cyc(3);
        chk("R6 restored", out_on, 8'hf0);

        // R8 / R9: shutdown with hysteresis
        tag = "R8";
        @(negedge clk); ot_hot = 1;
        cyc(4);
        chk("R8 shut", out_on, 8'h00);
        @(negedge clk); ot_hot = 0;
        cyc(6);
        tag = "R9";
        chk("R9 stays shut", out_on, 8'h00);
        @(negedge clk); ot_hot = 1; ot_cool = 1;
        cyc(5);
        chk("R9 hot wins", out_on, 8'h00);
        @(negedge clk); ot_hot = 0;
        cyc(4);
        chk("R9 released", out_on, 8'hf0);
        @(negedge clk); ot_cool = 0;
        cyc(2);

        // Random mix, compared every clock
        tag = "R4";
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            sel_n = ($urandom % 3) == 0;
            addr = 3'($urandom);
            din = $urandom;
            clr_n = ($urandom % 25) != 0;
            oe = ($urandom % 6) != 0;
            ot_hot = ($urandom % 40) == 0;
            ot_cool = ($urandom % 8) == 0;
        end
        cyc(5);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule